// File: doc/BRIEF.md
# Ping-Pong Write Master for a Two-Thread Synchronous FIFO Bridge

This block sits on the FPGA side of a synchronous slave FIFO bridge. It takes an upstream stream of 32-bit words on a valid/ready handshake and writes them into the bridge, one word per clock. The bridge has two hardware threads, chosen by a 2-bit address bus. The master fills one thread until that thread's partial flag says there is no room left. It then stops writing, moves the address to the other thread and carries on there. The threads take turns for as long as data arrives.

The bridge's status flags lag the address. After the address changes, the flags describe the new thread only from the third clock edge on. The master therefore counts out that latency after every address change. At the first trustworthy edge it samples the thread's ready flag, because the partial flag is not meaningful at the start of a transfer. Once writing has begun, only the partial flag governs stopping. Its watermark is set so that zero words of slack remain when it goes low. Upstream data is accepted only in cycles where a word is actually driven onto the bus, so no word is dropped while the master waits.

Top module: `sfifo_pingpong_wr`

## Requirements
- R1: During and directly after reset the write strobe `wr_n` is high (inactive), `thr_addr` is 0 and `src_ready` is low.
- R2: No word is written on the edge at which `thr_addr` changes, nor on the two edges that follow it. Flags are first sampled at the third edge after the address change, and the earliest write is on the fourth.
- R3: On arriving at a thread, the master qualifies writing on `flag_rdy_n`, which is active-low (0 means the thread can accept data). While that flag is 1 the master writes nothing and re-samples it on every edge.
- R4: If `flag_rdy_n` is 0 at the sampling edge, a word is written on the very next edge whenever `src_valid` is high in that cycle.
- R5: `flag_wm_n` is active-low (0 means the watermark is reached and no room is left). While writing, a cycle in which it is 0 has `wr_n` high, so no word is written.
- R6: After a cycle in which writing stopped on `flag_wm_n` = 0, the master spends exactly one further cycle in the switch step. `thr_addr` then changes on the following edge, which is the second edge after the stop cycle. The thread left behind holds exactly its capacity.
- R7: `thr_addr` takes only the values 0 and 1 and alternates strictly 0, 1, 0, 1, starting from 0.
- R8: A word is written (`wr_n` = 0) exactly in the cycles where `src_valid` and `src_ready` are both high. `bus_data` equals `src_data` in those cycles, so the written sequence matches the upstream order.
- R9: While writing with room left, a cycle with `src_valid` low writes nothing and does not cause a thread switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | Upstream word available |
| src_data | input | 32 | Upstream word |
| src_ready | output | 1 | Upstream word taken this cycle (when valid) |
| flag_rdy_n | input | 1 | Active-low ready flag of the addressed thread |
| flag_wm_n | input | 1 | Active-low partial (watermark) flag of the addressed thread |
| wr_n | output | 1 | Active-low write strobe to the bridge |
| bus_data | output | 32 | Data bus to the bridge |
| thr_addr | output | 2 | Thread select address |

## Verification
The hardest situation to reach from the ports is the return to a thread that is still full. There the master must sit in its ready check, ignore the misleading flag values shown during the latency window, and resume exactly one edge after the bridge reports room. The bench's bridge model drains each thread only after a random delay of up to 60 cycles, and it reports false "ready, no watermark" values until the latency has elapsed. Under the sparse-input phase this forces many revisits to a full thread, while a phase with continuous input and fast draining exercises the exact four-edge resume timing.

// File: rtl/pp_wr_pkg.sv
package pp_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_ADDR_WAIT = 3'd1,
        ST_CHECK     = 3'd2,
        ST_WRITE     = 3'd3,
        ST_SWITCH    = 3'd4
    } pp_state_e;

    // Width of a counter that must hold values 0..n-1 (at least one bit).
    function automatic int idx_width(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pp_settle_cnt.sv
module pp_settle_cnt #(
    parameter int SETTLE = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic done
);
    import pp_wr_pkg::*;

    localparam int CNT_W = idx_width(SETTLE);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE - 2);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (run && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && (cnt_q == LAST);

    // R2: the wait counter only advances while it is being run
    p_cnt_only_when_run_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != $past(cnt_q) && cnt_q != '0) |-> $past(run));

endmodule

// File: rtl/pp_thread_sel.sv
module pp_thread_sel #(
    parameter int THREADS = 2,
    parameter int ADDR_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr
);
    import pp_wr_pkg::*;

    localparam int SEL_W = idx_width(THREADS);
    localparam bit POW2  = (THREADS & (THREADS - 1)) == 0;

    logic [SEL_W-1:0] sel_q;
    logic [SEL_W-1:0] sel_nx;

    generate
        if (POW2) begin : g_wrap
            assign sel_nx = sel_q + 1'b1;
        end else begin : g_cmp
            assign sel_nx = (sel_q == SEL_W'(THREADS - 1)) ? '0 : sel_q + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (advance) begin
            sel_q <= sel_nx;
        end
    end

    assign addr = ADDR_W'(sel_q);

    // R7: selection stays inside the thread range
    p_sel_range_r7: assert property (@(posedge clk) disable iff (rst)
        int'(sel_q) < THREADS);

    // R7: selection moves only when the controller requests a switch
    p_sel_moves_on_advance_r7: assert property (@(posedge clk) disable iff (rst)
        (sel_q != $past(sel_q)) |-> $past(advance));

endmodule

// File: rtl/pp_wr_fsm.sv
module pp_wr_fsm (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 src_valid,
    input  logic                 flag_rdy_n,
    input  logic                 flag_wm_n,
    input  logic                 settle_done,
    output pp_wr_pkg::pp_state_e state,
    output logic                 cnt_clear,
    output logic                 cnt_run,
    output logic                 advance,
    output logic                 src_ready,
    output logic                 wr_n
);
    import pp_wr_pkg::*;

    pp_state_e state_q;
    pp_state_e state_nx;
    logic      room;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        state_nx  = state_q;
        cnt_clear = 1'b0;
        cnt_run   = 1'b0;
        advance   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_clear = 1'b1;
                state_nx  = ST_ADDR_WAIT;
            end
            ST_ADDR_WAIT: begin
                cnt_run = 1'b1;
                if (settle_done) state_nx = ST_CHECK;
            end
            ST_CHECK: begin
                if (!flag_rdy_n) state_nx = ST_WRITE;
            end
            ST_WRITE: begin
                if (!flag_wm_n) state_nx = ST_SWITCH;
            end
            ST_SWITCH: begin
                advance   = 1'b1;
                cnt_clear = 1'b1;
                state_nx  = ST_ADDR_WAIT;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign room      = (state_q == ST_WRITE) && flag_wm_n;
    assign src_ready = room;
    assign wr_n      = !(room && src_valid);
    assign state     = state_q;

    // R3: writing begins only after the ready flag was seen asserted in the check step
    p_enter_write_on_ready_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WRITE && $past(state_q) != ST_WRITE)
        |-> ($past(state_q) == ST_CHECK && !$past(flag_rdy_n)));

    // R6: a watermark hit while writing leads to the switch step next cycle
    p_wm_leads_to_switch_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WRITE && !flag_wm_n) |=> (state_q == ST_SWITCH && wr_n));

    // R9: with room left, the master stays in the write step
    p_stay_writing_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WRITE && flag_wm_n) |=> (state_q == ST_WRITE));

endmodule

// File: rtl/sfifo_pingpong_wr.sv
module sfifo_pingpong_wr #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 2,
    parameter int THREADS = 2,
    parameter int SETTLE  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready,
    input  logic              flag_rdy_n,
    input  logic              flag_wm_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] bus_data,
    output logic [ADDR_W-1:0] thr_addr
);
    import pp_wr_pkg::*;

    localparam int AGE_W = idx_width(SETTLE + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(SETTLE);

    pp_state_e state;
    logic      cnt_clear;
    logic      cnt_run;
    logic      settle_done;
    logic      advance;

    pp_wr_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .src_valid   (src_valid),
        .flag_rdy_n  (flag_rdy_n),
        .flag_wm_n   (flag_wm_n),
        .settle_done (settle_done),
        .state       (state),
        .cnt_clear   (cnt_clear),
        .cnt_run     (cnt_run),
        .advance     (advance),
        .src_ready   (src_ready),
        .wr_n        (wr_n)
    );

    pp_settle_cnt #(.SETTLE(SETTLE)) u_settle (
        .clk   (clk),
        .rst   (rst),
        .clear (cnt_clear),
        .run   (cnt_run),
        .done  (settle_done)
    );

    pp_thread_sel #(.THREADS(THREADS), .ADDR_W(ADDR_W)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .addr    (thr_addr)
    );

    assign bus_data = src_data;

    // Edges elapsed since the last address change, saturating; used by checks only.
    logic [AGE_W-1:0] addr_age_q;
    always_ff @(posedge clk) begin
        if (rst || advance) begin
            addr_age_q <= '0;
        end else if (addr_age_q != AGE_MAX) begin
            addr_age_q <= addr_age_q + 1'b1;
        end
    end

    // R2: the ready check is never reached before the flag latency has elapsed
    p_check_after_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK) |-> (int'(addr_age_q) >= SETTLE - 1));

    // R2: no write in a cycle whose address was just changed
    p_no_write_on_new_addr_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> $stable(thr_addr));

    // R6: the address moves only out of the switch step
    p_addr_moves_from_switch_r6: assert property (@(posedge clk) disable iff (rst)
        (thr_addr != $past(thr_addr)) |-> ($past(state) == ST_SWITCH));

endmodule

// File: tb/sfifo_pingpong_wr_bench.sv
module sfifo_pingpong_wr_bench;

    localparam int DW       = 32;
    localparam int AW       = 2;
    localparam int CAP0     = 12;
    localparam int CAP1     = 20;
    localparam int RUN_CYC  = 9000;
    localparam int WATCHDOG = 200000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          src_valid = 1'b0;
    logic [DW-1:0] src_data = '0;
    logic          src_ready;
    logic          flag_rdy_n;
    logic          flag_wm_n;
    logic          wr_n;
    logic [DW-1:0] bus_data;
    logic [AW-1:0] thr_addr;

    always #4 clk = ~clk;

    sfifo_pingpong_wr u_sfifo_pingpong_wr (
        .clk        (clk),
        .rst        (rst),
        .src_valid  (src_valid),
        .src_data   (src_data),
        .src_ready  (src_ready),
        .flag_rdy_n (flag_rdy_n),
        .flag_wm_n  (flag_wm_n),
        .wr_n       (wr_n),
        .bus_data   (bus_data),
        .thr_addr   (thr_addr)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] word_of(input int k);
        return (32'(k) * 32'h9E37_79B9) + 32'h1234_5678;
    endfunction

    function automatic int cap_of(input int t);
        return (t == 0) ? CAP0 : CAP1;
    endfunction

    // ---------------- bridge model ----------------
    int         fill   [2];
    int         drain_t[2];
    logic [AW-1:0] last_addr;
    int         age;
    bit         full_here;
    int         dmax = 40;

    logic          s_wr_n = 1'b1;
    logic [AW-1:0] s_addr = '0;
    bit            acc_snap = 1'b0;

    always_comb begin
        if (age < 2) begin
            flag_rdy_n = 1'b0;   // misleading values inside the latency window
            flag_wm_n  = 1'b1;
        end else begin
            flag_rdy_n = fill[int'(last_addr[0])] >= cap_of(int'(last_addr[0]));
            flag_wm_n  = !(fill[int'(last_addr[0])] >= cap_of(int'(last_addr[0])));
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            fill[0] <= 0; fill[1] <= 0;
            drain_t[0] <= 0; drain_t[1] <= 0;
            last_addr <= '0;
            age <= 0;
            full_here <= 1'b0;
        end else begin
            if (s_addr != last_addr) begin
                last_addr <= s_addr;
                age <= 1;
                full_here <= 1'b0;
            end else begin
                if (age < 7) age <= age + 1;
                if (!s_wr_n && fill[int'(s_addr[0])] + 1 >= cap_of(int'(s_addr[0])))
                    full_here <= 1'b1;
            end
            for (int t = 0; t < 2; t++) begin
                if (!s_wr_n && int'(s_addr[0]) == t) begin
                    fill[t] <= fill[t] + 1;
                    if (fill[t] + 1 >= cap_of(t)) drain_t[t] <= $urandom_range(dmax, 3);
                end else if (fill[t] >= cap_of(t)) begin
                    if (drain_t[t] == 0) fill[t] <= 0;
                    else drain_t[t] <= drain_t[t] - 1;
                end
            end
        end
    end

    // ---------------- observation ----------------
    int wr_idx = 0;
    int switches = 0;
    int stall = 0;
    bit seen_switch = 1'b0;
    bit pend_ok = 1'b0;
    int t_cur;

    always @(negedge clk) begin
        s_wr_n   <= wr_n;
        s_addr   <= thr_addr;
        acc_snap = src_valid && src_ready;
        if (rst) begin
            chk(wr_n == 1'b1, "R1", "wr_n in reset", 64'(wr_n), 1);
            chk(thr_addr == '0, "R1", "thr_addr in reset", 64'(thr_addr), 0);
            chk(src_ready == 1'b0, "R1", "src_ready in reset", 64'(src_ready), 0);
        end else if (!finished) begin
            t_cur = int'(thr_addr[0]);
            chk((src_valid && src_ready) == !wr_n, "R8", "handshake vs strobe",
                64'(!wr_n), 64'(src_valid && src_ready));
            if (!wr_n) begin
                chk(thr_addr < 2, "R7", "address range", 64'(thr_addr), 1);
                chk(fill[t_cur] < cap_of(t_cur), "R5", "write into full thread",
                    64'(fill[t_cur]), 64'(cap_of(t_cur) - 1));
                chk(thr_addr == last_addr && age >= 3, "R2", "write age after address change",
                    64'(age), 3);
                chk(bus_data == word_of(wr_idx), "R8", "word order",
                    64'(bus_data), 64'(word_of(wr_idx)));
                wr_idx++;
            end
            if (thr_addr != last_addr) begin
                switches++;
                chk(thr_addr == {1'b0, ~last_addr[0]}, "R7", "alternation",
                    64'(thr_addr), 64'({1'b0, ~last_addr[0]}));
                chk(fill[int'(last_addr[0])] == cap_of(int'(last_addr[0])), "R6",
                    "thread left not full", 64'(fill[int'(last_addr[0])]),
                    64'(cap_of(int'(last_addr[0]))));
                chk(stall == 2, "R6", "cycles from stop to address change", 64'(stall), 2);
                stall = 0;
                seen_switch = 1'b1;
            end else begin
                if (full_here) stall++;
                if (seen_switch && age == 2) pend_ok = fill[t_cur] < cap_of(t_cur);
                if (seen_switch && age == 3) begin
                    if (pend_ok && src_valid)
                        chk(!wr_n, "R4", "write right after ready sample", 64'(wr_n), 0);
                    if (!pend_ok)
                        chk(wr_n, "R3", "no write while ready flag inactive", 64'(wr_n), 1);
                end
                if (age >= 3 && full_here == 1'b0 && fill[t_cur] < cap_of(t_cur)
                    && !src_valid && seen_switch && pend_ok)
                    chk(wr_n, "R9", "idle input writes nothing", 64'(wr_n), 1);
            end
        end
    end

    // ---------------- stimulus ----------------
    int src_idx = 0;
    int pct;

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(wr_n == 1'b1 && thr_addr == '0 && src_ready == 1'b0, "R1",
            "state after reset", 64'({wr_n, thr_addr, src_ready}), 64'(4'b1000));
        for (int cyc = 0; cyc < RUN_CYC; cyc++) begin
            @(posedge clk);
            #1;
            if (cyc < 3000)      begin pct = 70;  dmax = 40; end
            else if (cyc < 6000) begin pct = 100; dmax = 3;  end
            else                 begin pct = 20;  dmax = 60; end
            if (acc_snap) src_idx++;
            src_data = word_of(src_idx);
            if (!(src_valid && !acc_snap))
                src_valid = ($urandom_range(99, 0) < pct);
        end
        @(negedge clk);
        finished = 1'b1;
        chk(wr_idx > 500, "R4", "words written", 64'(wr_idx), 501);
        chk(switches > 20, "R7", "thread switches", 64'(switches), 21);
        chk(wr_idx == src_idx, "R8", "accepted equals written", 64'(wr_idx), 64'(src_idx));
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", WATCHDOG, RUN_CYC);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule